// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block sits beside the fetch stage of an out-of-order core. It decides, for each fetched load or store, whether the instruction should be held until an earlier store resolves its address. It remembers pairs of loads and stores that collided in the past and places them in a common group, called a store set. The first table, indexed by instruction address, maps an instruction to a set number. The second table, indexed by set number, holds the tag of the youngest store of that set that has been fetched and has not yet resolved its address. A fetched load or store in a known set is told to wait on that tag. Every other load or store goes ahead speculatively.

The block has three inputs. At fetch, it looks up each instruction and reports a dependence one cycle later. When a store resolves its address, the store clears its own entry in the second table. When a violation is detected, the training port receives the load and store addresses and merges them into one set. The set is newly allocated, inherited from one of the two, or the smaller of the two set numbers.

Top module: `store_set_pred`

## Requirements
- R1: After reset every entry of both tables is invalid, and dep_vld is 0 while in reset and for the first fetch after reset.
- R2: dep_vld and dep_inum are registered. They describe the fetch of the previous cycle, and dep_vld is 0 in any cycle after a cycle with fetch_vld low.
- R3: The address-to-set table is indexed by PC bits [7:2]. A fetched instruction whose entry is invalid reports no dependence and leaves the store table unchanged.
- R4: A fetched load whose set is valid reports dep_vld=1 with the tag held for its set when that set entry is valid, and dep_vld=0 otherwise.
- R5: A fetched store whose set is valid reports the previous tag of its set in the same way as a load. It then becomes the tag of that set.
- R6: A resolving store clears its set's tag only when the held tag equals res_inum. A load fetched in the same cycle as such a clear sees no dependence.
- R7: When training finds neither address in a set, both receive a new set number from a counter. The counter starts at 0 after reset and steps by one, modulo 16, on each such allocation only.
- R8: When training finds only one of the two addresses in a set, the other address is given that set number.
- R9: When training finds both addresses in sets, both are given the smaller of the two set numbers.
- R10: When a fetch lookup and a training write target the same address-table entry in the same cycle, the lookup uses the newly trained set number.
- R11: When a store of a set is fetched in the same cycle as the previous store of that set resolves, the fetched store reports no dependence and still becomes the set's tag.
- R12: Addresses that differ only outside bits [7:2] share one table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_vld | input | 1 | A load or store is fetched this cycle |
| fetch_is_store | input | 1 | 1 for a store, 0 for a load |
| fetch_pc | input | PC_W | Address of the fetched instruction |
| fetch_inum | input | INUM_W | Tag of the fetched instruction |
| res_vld | input | 1 | A store resolves its address this cycle |
| res_pc | input | PC_W | Address of the resolving store |
| res_inum | input | INUM_W | Tag of the resolving store |
| train_vld | input | 1 | A violation report is presented |
| train_ld_pc | input | PC_W | Address of the violating load |
| train_st_pc | input | PC_W | Address of the store it depended on |
| dep_vld | output | 1 | Previous fetch must wait on dep_inum |
| dep_inum | output | INUM_W | Tag of the store to wait on |

## Verification
The bench uses the default parameters: 64 address entries, 16 sets and 6-bit tags. With 16 sets, the round-robin counter wraps after sixteen allocations, so a short sequence reaches the wrap. Sharing of a set number after the wrap then shows up as a dependence between two pairs that were trained separately. The choice of the smaller set number on a merge is visible only through which stores a load waits on afterwards. The same-cycle cases (training with lookup, resolve with store fetch, resolve with load fetch) are driven in single cycles.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    MRG_ALLOC   = 2'd0,
    MRG_TAKE_LD = 2'd1,
    MRG_TAKE_ST = 2'd2,
    MRG_MIN     = 2'd3
  } merge_e;

  function automatic merge_e merge_kind(input logic ld_hit, input logic st_hit);
    if (ld_hit && st_hit) return MRG_MIN;
    if (ld_hit)           return MRG_TAKE_LD;
    if (st_hit)           return MRG_TAKE_ST;
    return MRG_ALLOC;
  endfunction
endpackage

// File: rtl/ssp_ssit.sv
module ssp_ssit #(
  parameter int IDX_W = 6,
  parameter int ID_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] fet_idx,
  output logic             fet_hit,
  output logic [ID_W-1:0]  fet_id,
  input  logic [IDX_W-1:0] res_idx,
  output logic             res_hit,
  output logic [ID_W-1:0]  res_id,
  input  logic [IDX_W-1:0] tld_idx,
  output logic             tld_hit,
  output logic [ID_W-1:0]  tld_id,
  input  logic [IDX_W-1:0] tst_idx,
  output logic             tst_hit,
  output logic [ID_W-1:0]  tst_id,
  input  logic             wr_en,
  input  logic [ID_W-1:0]  wr_id
);
  localparam int ENTRIES = 1 << IDX_W;

  logic            vld_q [ENTRIES];
  logic [ID_W-1:0] id_q  [ENTRIES];
  logic            vld_d [ENTRIES];
  logic [ID_W-1:0] id_d  [ENTRIES];

  // Training reads use the stored state.
  always_comb begin
    tld_hit = vld_q[tld_idx];
    tld_id  = id_q[tld_idx];
    tst_hit = vld_q[tst_idx];
    tst_id  = id_q[tst_idx];
  end

  // Lookups see a training write to the same entry in the same cycle.
  always_comb begin
    if (wr_en && (tld_idx == fet_idx || tst_idx == fet_idx)) begin
      fet_hit = 1'b1;
      fet_id  = wr_id;
    end else begin
      fet_hit = vld_q[fet_idx];
      fet_id  = id_q[fet_idx];
    end
    if (wr_en && (tld_idx == res_idx || tst_idx == res_idx)) begin
      res_hit = 1'b1;
      res_id  = wr_id;
    end else begin
      res_hit = vld_q[res_idx];
      res_id  = id_q[res_idx];
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      vld_d[i] = vld_q[i];
      id_d[i]  = id_q[i];
    end
    if (wr_en) begin
      vld_d[tld_idx] = 1'b1;
      id_d[tld_idx]  = wr_id;
      vld_d[tst_idx] = 1'b1;
      id_d[tst_idx]  = wr_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vld_q[i] <= 1'b0;
        id_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        vld_q[i] <= vld_d[i];
        id_q[i]  <= id_d[i];
      end
    end
  end

  // R8
  merged_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(tld_idx)] && vld_q[$past(tst_idx)] &&
              id_q[$past(tld_idx)] == id_q[$past(tst_idx)]);
endmodule

// File: rtl/ssp_lfst.sv
module ssp_lfst #(
  parameter int ID_W   = 4,
  parameter int INUM_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   rd_id,
  output logic              rd_vld,
  output logic [INUM_W-1:0] rd_inum,
  input  logic              set_en,
  input  logic [ID_W-1:0]   set_id,
  input  logic [INUM_W-1:0] set_inum,
  input  logic              clr_en,
  input  logic [ID_W-1:0]   clr_id,
  input  logic [INUM_W-1:0] clr_inum
);
  localparam int SETS = 1 << ID_W;

  logic              vld_q  [SETS];
  logic [INUM_W-1:0] inum_q [SETS];
  logic              vld_d  [SETS];
  logic [INUM_W-1:0] inum_d [SETS];
  logic              clr_hit;

  assign clr_hit = clr_en && vld_q[clr_id] && (inum_q[clr_id] == clr_inum);

  always_comb begin
    rd_vld  = vld_q[rd_id] && !(clr_hit && clr_id == rd_id);
    rd_inum = inum_q[rd_id];
  end

  always_comb begin
    for (int i = 0; i < SETS; i++) begin
      vld_d[i]  = vld_q[i];
      inum_d[i] = inum_q[i];
    end
    if (clr_hit) vld_d[clr_id] = 1'b0;
    if (set_en) begin
      vld_d[set_id]  = 1'b1;
      inum_d[set_id] = set_inum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        vld_q[i]  <= 1'b0;
        inum_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < SETS; i++) begin
        vld_q[i]  <= vld_d[i];
        inum_q[i] <= inum_d[i];
      end
    end
  end

  // R5
  store_becomes_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> vld_q[$past(set_id)] && inum_q[$past(set_id)] == $past(set_inum));

  // R6
  stale_clear_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && vld_q[clr_id] && inum_q[clr_id] != clr_inum &&
     !(set_en && set_id == clr_id))
    |=> vld_q[$past(clr_id)] && inum_q[$past(clr_id)] == $past(inum_q[clr_id]));
endmodule

// File: rtl/ssp_train.sv
module ssp_train
  import ssp_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            train_vld,
  input  logic            ld_hit,
  input  logic [ID_W-1:0] ld_id,
  input  logic            st_hit,
  input  logic [ID_W-1:0] st_id,
  output logic            wr_en,
  output logic [ID_W-1:0] wr_id
);
  logic [ID_W-1:0] rr_q;
  logic [ID_W-1:0] rr_d;
  logic            alloc;
  merge_e          kind;

  assign kind  = merge_kind(ld_hit, st_hit);
  assign wr_en = train_vld;
  assign alloc = train_vld && (kind == MRG_ALLOC);

  always_comb begin
    case (kind)
      MRG_TAKE_LD: wr_id = ld_id;
      MRG_TAKE_ST: wr_id = st_id;
      MRG_MIN:     wr_id = (ld_id < st_id) ? ld_id : st_id;
      default:     wr_id = rr_q;
    endcase
  end

  always_comb begin
    rr_d = rr_q;
    if (alloc) rr_d = rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  // R7
  rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc |=> $stable(rr_q));

  // R7
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> rr_q == ID_W'($past(rr_q) + 1));

  // R9
  merge_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (train_vld && ld_hit && st_hit) |-> (wr_id <= ld_id && wr_id <= st_id));
endmodule

// File: rtl/store_set_pred.sv
module store_set_pred #(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int IDX_W  = 6,
  parameter int ID_W   = 4,
  parameter int INUM_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_vld,
  input  logic              fetch_is_store,
  input  logic [PC_W-1:0]   fetch_pc,
  input  logic [INUM_W-1:0] fetch_inum,
  input  logic              res_vld,
  input  logic [PC_W-1:0]   res_pc,
  input  logic [INUM_W-1:0] res_inum,
  input  logic              train_vld,
  input  logic [PC_W-1:0]   train_ld_pc,
  input  logic [PC_W-1:0]   train_st_pc,
  output logic              dep_vld,
  output logic [INUM_W-1:0] dep_inum
);
  logic [IDX_W-1:0]  fet_idx, res_idx, tld_idx, tst_idx;
  logic              fet_hit, res_hit, tld_hit, tst_hit;
  logic [ID_W-1:0]   fet_id, res_id, tld_id, tst_id;
  logic              wr_en;
  logic [ID_W-1:0]   wr_id;
  logic              lf_vld;
  logic [INUM_W-1:0] lf_inum;
  logic              f_hit, dep_d;
  logic              dep_vld_q;
  logic [INUM_W-1:0] dep_inum_q;
  logic              pc_unused;

  assign fet_idx = fetch_pc[PC_LSB +: IDX_W];
  assign res_idx = res_pc[PC_LSB +: IDX_W];
  assign tld_idx = train_ld_pc[PC_LSB +: IDX_W];
  assign tst_idx = train_st_pc[PC_LSB +: IDX_W];
  assign pc_unused = ^{fetch_pc, res_pc, train_ld_pc, train_st_pc};

  ssp_ssit #(.IDX_W(IDX_W), .ID_W(ID_W)) u_ssit (
    .clk(clk), .rst_n(rst_n),
    .fet_idx(fet_idx), .fet_hit(fet_hit), .fet_id(fet_id),
    .res_idx(res_idx), .res_hit(res_hit), .res_id(res_id),
    .tld_idx(tld_idx), .tld_hit(tld_hit), .tld_id(tld_id),
    .tst_idx(tst_idx), .tst_hit(tst_hit), .tst_id(tst_id),
    .wr_en(wr_en), .wr_id(wr_id)
  );

  ssp_train #(.ID_W(ID_W)) u_train (
    .clk(clk), .rst_n(rst_n), .train_vld(train_vld),
    .ld_hit(tld_hit), .ld_id(tld_id), .st_hit(tst_hit), .st_id(tst_id),
    .wr_en(wr_en), .wr_id(wr_id)
  );

  assign f_hit = fetch_vld && fet_hit;

  ssp_lfst #(.ID_W(ID_W), .INUM_W(INUM_W)) u_lfst (
    .clk(clk), .rst_n(rst_n),
    .rd_id(fet_id), .rd_vld(lf_vld), .rd_inum(lf_inum),
    .set_en(f_hit && fetch_is_store), .set_id(fet_id), .set_inum(fetch_inum),
    .clr_en(res_vld && res_hit), .clr_id(res_id), .clr_inum(res_inum)
  );

  assign dep_d = f_hit && lf_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dep_vld_q  <= 1'b0;
      dep_inum_q <= '0;
    end else begin
      dep_vld_q <= dep_d;
      if (dep_d) dep_inum_q <= lf_inum;
    end
  end

  assign dep_vld  = dep_vld_q;
  assign dep_inum = dep_inum_q;

  // R2
  no_fetch_no_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld |=> !dep_vld);

  // R3
  unknown_pc_no_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && !fet_hit) |=> !dep_vld);
endmodule

// File: tb/tb_store_set_pred.sv
module tb_store_set_pred;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_vld, fetch_is_store, res_vld, train_vld;
  logic [31:0] fetch_pc, res_pc, train_ld_pc, train_st_pc;
  logic [5:0]  fetch_inum, res_inum;
  logic        dep_vld;
  logic [5:0]  dep_inum;
  int checks = 0;
  int errors = 0;

  store_set_pred dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_vld(fetch_vld), .fetch_is_store(fetch_is_store),
    .fetch_pc(fetch_pc), .fetch_inum(fetch_inum),
    .res_vld(res_vld), .res_pc(res_pc), .res_inum(res_inum),
    .train_vld(train_vld), .train_ld_pc(train_ld_pc), .train_st_pc(train_st_pc),
    .dep_vld(dep_vld), .dep_inum(dep_inum)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {is_store, high_alias, idx[5:0], inum[5:0], exp_vld, exp_inum[5:0]}
  localparam logic [20:0] VEC [0:7] = '{
    {1'b1, 1'b0, 6'd2, 6'd5,  1'b0, 6'd0},
    {1'b0, 1'b0, 6'd1, 6'd6,  1'b1, 6'd5},
    {1'b1, 1'b0, 6'd2, 6'd7,  1'b1, 6'd5},
    {1'b0, 1'b0, 6'd1, 6'd8,  1'b1, 6'd7},
    {1'b0, 1'b0, 6'd3, 6'd9,  1'b0, 6'd0},
    {1'b0, 1'b1, 6'd1, 6'd10, 1'b1, 6'd7},
    {1'b1, 1'b0, 6'd3, 6'd11, 1'b0, 6'd0},
    {1'b0, 1'b0, 6'd1, 6'd12, 1'b1, 6'd7}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 2:    return "R5";
      1, 3:    return "R4";
      5:       return "R12";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [31:0] pc_of(input int idx, input logic hi);
    return (hi ? 32'h0000_1000 : 32'h0) | (32'(idx) << 2);
  endfunction

  task automatic check(input string tag, input logic ev, input logic [5:0] ei);
    checks++;
    if (dep_vld !== ev || (ev && dep_inum !== ei)) begin
      errors++;
      $display("FAIL %s: dep_vld=%0b dep_inum=%0d expected dep_vld=%0b dep_inum=%0d",
               tag, dep_vld, dep_inum, ev, ei);
    end
  endtask

  // Entered at a falling edge; checks the registered result one cycle later.
  task automatic fetch_chk(input logic st, input int idx, input logic hi,
                           input logic [5:0] inum, input logic ev,
                           input logic [5:0] ei, input string tag);
    fetch_vld      = 1'b1;
    fetch_is_store = st;
    fetch_pc       = pc_of(idx, hi);
    fetch_inum     = inum;
    @(negedge clk);
    fetch_vld = 1'b0;
    check(tag, ev, ei);
  endtask

  task automatic train(input int ld_idx, input int st_idx);
    train_vld   = 1'b1;
    train_ld_pc = pc_of(ld_idx, 1'b0);
    train_st_pc = pc_of(st_idx, 1'b0);
    @(negedge clk);
    train_vld = 1'b0;
  endtask

  task automatic resolve(input int idx, input logic [5:0] inum);
    res_vld  = 1'b1;
    res_pc   = pc_of(idx, 1'b0);
    res_inum = inum;
    @(negedge clk);
    res_vld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fetch_vld = 1'b0; fetch_is_store = 1'b0; fetch_pc = '0; fetch_inum = '0;
    res_vld = 1'b0; res_pc = '0; res_inum = '0;
    train_vld = 1'b0; train_ld_pc = '0; train_st_pc = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 6'd0);
    rst_n = 1'b1;
    @(negedge clk);
    fetch_chk(1'b0, 1, 1'b0, 6'd1, 1'b0, 6'd0, "R1 first fetch");

    // New pair takes set 0 (R7)
    train(1, 2);
    for (int i = 0; i < 8; i++) begin
      logic [20:0] v;
      v = VEC[i];
      fetch_chk(v[20], int'(v[18:13]), v[19], v[12:7], v[6], v[5:0], vec_tag(i));
    end

    // R2: idle cycle gives no dependence
    @(negedge clk);
    check("R2 idle", 1'b0, 6'd0);

    // R6: stale resolve keeps tag, matching resolve clears it
    resolve(2, 6'd5);
    fetch_chk(1'b0, 1, 1'b0, 6'd13, 1'b1, 6'd7, "R6 stale resolve");
    resolve(2, 6'd7);
    fetch_chk(1'b0, 1, 1'b0, 6'd14, 1'b0, 6'd0, "R6 matching resolve");

    // R11: store fetch together with resolve of the previous store
    fetch_chk(1'b1, 2, 1'b0, 6'd20, 1'b0, 6'd0, "R11 setup");
    res_vld = 1'b1; res_pc = pc_of(2, 1'b0); res_inum = 6'd20;
    fetch_chk(1'b1, 2, 1'b0, 6'd21, 1'b0, 6'd0, "R11 store with resolve");
    res_vld = 1'b0;
    fetch_chk(1'b0, 1, 1'b0, 6'd22, 1'b1, 6'd21, "R11 store wins");
    // R6: load in the same cycle as the clear
    res_vld = 1'b1; res_pc = pc_of(2, 1'b0); res_inum = 6'd21;
    fetch_chk(1'b0, 1, 1'b0, 6'd23, 1'b0, 6'd0, "R6 load with clear");
    res_vld = 1'b0;

    // R8: inherit in both directions
    train(4, 2);
    fetch_chk(1'b1, 2, 1'b0, 6'd30, 1'b0, 6'd0, "R8 setup");
    fetch_chk(1'b0, 4, 1'b0, 6'd31, 1'b1, 6'd30, "R8 load inherits");
    train(1, 5);
    fetch_chk(1'b1, 5, 1'b0, 6'd32, 1'b1, 6'd30, "R8 store inherits");

    // R7: second allocation is a separate set (set 1)
    train(10, 11);
    fetch_chk(1'b1, 11, 1'b0, 6'd33, 1'b0, 6'd0, "R7 new set");
    fetch_chk(1'b0, 1, 1'b0, 6'd34, 1'b1, 6'd32, "R7 sets apart");
    fetch_chk(1'b0, 10, 1'b0, 6'd35, 1'b1, 6'd33, "R7 own set");

    // R9: load in set 1, store in set 0 -> both set 0
    train(10, 2);
    fetch_chk(1'b1, 2, 1'b0, 6'd36, 1'b1, 6'd32, "R9 setup");
    fetch_chk(1'b0, 10, 1'b0, 6'd37, 1'b1, 6'd36, "R9 smaller set");
    fetch_chk(1'b1, 11, 1'b0, 6'd38, 1'b1, 6'd33, "R9 other stays");

    // R7: allocate sets 2..15, then the counter wraps to 0
    for (int k = 0; k < 14; k++) train(20 + k, 40 + k);
    fetch_chk(1'b1, 53, 1'b0, 6'd40, 1'b0, 6'd0, "R7 set 15 fresh");
    train(60, 61);
    fetch_chk(1'b1, 61, 1'b0, 6'd39, 1'b1, 6'd36, "R7 wrap to set 0");

    // R10: training and lookup of the same entry in one cycle
    train_vld = 1'b1; train_ld_pc = pc_of(62, 1'b0); train_st_pc = pc_of(2, 1'b0);
    fetch_chk(1'b0, 62, 1'b0, 6'd41, 1'b1, 6'd39, "R10 training bypass");
    train_vld = 1'b0;

    @(negedge clk);
    check("R2 final idle", 1'b0, 6'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule